// File: doc/BRIEF.md
# I2C Master Byte Command Engine

This block drives an I2C bus as controller, one step per host command. The host loads a byte into the transmit half of a byte buffer and writes a command word. The command can ask for a START condition, one transmitted byte, one received byte, a STOP condition, or a legal mix of these. The engine carries out the steps in a fixed order: START, then transmit, then receive, then STOP. When a step finishes, the engine sets a sticky status bit. Between steps the engine holds SCL low, so the host can pace a transfer at interrupt speed.

A received byte appears in the upper half of the byte buffer. A flag in the command chooses whether the engine answers the received byte with ACK or NACK. If a transmitted 1 is read back as 0 while SCL is high, the engine reports loss of arbitration, releases both lines and drops any steps still pending. A command that assumes the engine owns the bus when it does not is reported as abnormal and is not executed. All bus timing is derived from an external tick: one bit takes four ticks.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, SCL and SDA are released, the status is 0, the interrupt is low, busy is low and the buffer reads 0.
- R2: Command bits 0 (START) and 1 (TX) together produce a START condition and then shift out buf[7:0], MSB first. Afterwards status bit 0 is set if the target ACKed, or status bit 1 if it NAKed, never both.
- R3: Command bit 1 alone, issued while the bus is held, shifts out the buffer byte and reports ACK or NAK the same way as R2.
- R4: Command bit 3 (RX) receives one byte MSB first. The engine returns it in buf_o[15:8], sets status bit 2 and drives ACK when command bit 4 is clear.
- R5: When command bit 4 (LAST) is set together with RX, the engine leaves SDA released in the acknowledge slot, which is a NACK.
- R6: START, TX and RX in one command receive the first data byte right after an ACKed address, and set status bits 0 and 2. After a NAK, the receive step is dropped.
- R7: Command bit 5 (STOP) raises SDA while SCL is high. Status bit 4 is set only once both lines are released and the engine is idle.
- R8: Status bits stay set until the host writes 1 to the matching bit of sts_clr_i. Writing 0 leaves a bit unchanged.
- R9: irq_o is high exactly when some status bit and the enable bit at the same position are both 1.
- R10: If SDA reads low while SCL is high in a bit where the engine sends 1, the engine sets status bit 3, releases both lines, drops the pending steps and returns to idle.
- R11: In these cases the engine sets status bit 5, executes nothing and leaves the lines untouched: a command in idle without START, or any command with reserved bit 2 set.
- R12: A command written while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus timing strobe; one bit takes four ticks |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 6 | Command word (START 0, TX 1, reserved 2, RX 3, LAST 4, STOP 5) |
| buf_we_i | input | 1 | Transmit byte write strobe |
| buf_i | input | 8 | Transmit byte |
| buf_o | output | 16 | {received byte, transmit byte} |
| irq_en_i | input | 6 | Interrupt enables, same positions as the status bits |
| sts_clr_i | input | 6 | Write-1-to-clear strobe for the status bits |
| sts_o | output | 6 | Status (ACK 0, NAK 1, RX 2, ARB 3, STOP 4, ABNORMAL 5) |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | A step is in progress |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the bus levels come back through the open-drain wiring. They also assume that a 1 on sts_clr_i is the host's only way to lower a status bit. Given those two assumptions, a rising edge of the stop or arbitration status must find both enables low. The bench closes the loop by modelling the wired-AND bus and a target that changes SDA only while SCL is low. The target has one exception: a jam mode that holds SDA low for the arbitration case. Commands are issued away from the clock edge, and each one waits for busy_o to fall before the next, except where the ignore rule is tested on purpose.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int CMD_W  = 6;
  localparam int STS_W  = 6;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam int C_START = 0;
  localparam int C_TX    = 1;
  localparam int C_RSVD  = 2;
  localparam int C_RX    = 3;
  localparam int C_LAST  = 4;
  localparam int C_STOP  = 5;

  localparam int S_ACK = 0;
  localparam int S_NAK = 1;
  localparam int S_RXD = 2;
  localparam int S_ARB = 3;
  localparam int S_STP = 4;
  localparam int S_ABN = 5;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_START, ST_TX, ST_RX, ST_STOP} st_e;
endpackage

// File: rtl/i2c_eng_bitio.sv
module i2c_eng_bitio
  import i2c_eng_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  op_e  op_i,
  input  logic wr_i,
  input  logic arb_en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic done_o,
  output logic rd_o,
  output logic arb_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  logic       active;
  logic [1:0] ph;
  op_e        op_q;
  logic       wr_q, arb_q;

  assign busy_o = active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active   <= 1'b0;
      ph       <= '0;
      op_q     <= OP_BIT;
      wr_q     <= 1'b1;
      arb_q    <= 1'b0;
      done_o   <= 1'b0;
      arb_o    <= 1'b0;
      rd_o     <= 1'b1;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      arb_o  <= 1'b0;
      if (!active) begin
        if (req_i) begin
          active <= 1'b1;
          ph     <= '0;
          op_q   <= op_i;
          wr_q   <= wr_i;
          arb_q  <= arb_en_i;
        end
      end else if (tick_i) begin
        ph <= ph + 2'd1;
        if (ph == 2'd3) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end
        case (op_q)
          OP_START: begin
            if (ph == 2'd0) sda_oe_o <= 1'b0;
            if (ph == 2'd1) scl_oe_o <= 1'b0;
            if (ph == 2'd2) sda_oe_o <= 1'b1;  // SDA falls, SCL high
            if (ph == 2'd3) scl_oe_o <= 1'b1;
          end
          OP_STOP: begin
            if (ph == 2'd0) begin sda_oe_o <= 1'b1; scl_oe_o <= 1'b1; end
            if (ph == 2'd1) scl_oe_o <= 1'b0;
            if (ph == 2'd2) sda_oe_o <= 1'b0;  // SDA rises, SCL high
          end
          default: begin
            if (ph == 2'd0) sda_oe_o <= ~wr_q;
            if (ph == 2'd1) scl_oe_o <= 1'b0;
            if (ph == 2'd2) begin
              rd_o <= sda_i;
              if (arb_q && wr_q && scl_i && !sda_i) begin
                arb_o    <= 1'b1;
                active   <= 1'b0;
                sda_oe_o <= 1'b0;
                scl_oe_o <= 1'b0;
              end
            end
            if (ph == 2'd3) scl_oe_o <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
  import i2c_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              io_busy_i,
  input  logic              io_done_i,
  input  logic              io_rd_i,
  input  logic              io_arb_i,
  output logic              io_req_o,
  output op_e               io_op_o,
  output logic              io_wr_o,
  output logic              io_arb_en_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [STS_W-1:0]  sts_set_o,
  output logic              busy_o
);
  st_e               st;
  logic              p_start, p_tx, p_rx, p_last, p_stop;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  logic              accept, abn, last_bit, step;

  function automatic st_e pick(input logic s, input logic t, input logic r, input logic p);
    if (s)      return ST_START;
    else if (t) return ST_TX;
    else if (r) return ST_RX;
    else if (p) return ST_STOP;
    else        return ST_HOLD;
  endfunction

  assign busy_o   = (st != ST_IDLE) && (st != ST_HOLD);
  assign step     = busy_o;
  assign accept   = cmd_we_i && !busy_o;
  assign abn      = accept && (cmd_i[C_RSVD] || (st == ST_IDLE && !cmd_i[C_START]));
  assign last_bit = (bcnt == CNT_W'(BYTE_W));

  always_comb begin
    io_req_o    = step && !io_busy_i && !io_done_i && !io_arb_i;
    io_op_o     = (st == ST_START) ? OP_START : (st == ST_STOP) ? OP_STOP : OP_BIT;
    io_wr_o     = 1'b1;
    io_arb_en_o = 1'b0;
    if (st == ST_TX && !last_bit) begin
      io_wr_o     = tx_sh[BYTE_W-1];
      io_arb_en_o = 1'b1;
    end
    if (st == ST_RX && last_bit) io_wr_o = p_last;
    sts_set_o = '0;
    sts_set_o[S_ABN] = abn;
    sts_set_o[S_ARB] = io_arb_i;
    if (io_done_i && st == ST_TX && last_bit) begin
      sts_set_o[S_ACK] = !io_rd_i;
      sts_set_o[S_NAK] = io_rd_i;
    end
    sts_set_o[S_RXD] = io_done_i && st == ST_RX && last_bit;
    sts_set_o[S_STP] = io_done_i && st == ST_STOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;
      {p_start, p_tx, p_rx, p_last, p_stop} <= '0;
      bcnt      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_byte_o <= '0;
    end else if (io_arb_i) begin
      st <= ST_IDLE;
      {p_start, p_tx, p_rx, p_last, p_stop} <= '0;
    end else if (accept && !abn) begin
      p_start <= cmd_i[C_START];
      p_tx    <= cmd_i[C_TX];
      p_rx    <= cmd_i[C_RX];
      p_last  <= cmd_i[C_LAST];
      p_stop  <= cmd_i[C_STOP];
      tx_sh   <= tx_byte_i;
      bcnt    <= '0;
      st      <= pick(cmd_i[C_START], cmd_i[C_TX], cmd_i[C_RX], cmd_i[C_STOP]);
    end else if (io_done_i) begin
      case (st)
        ST_START: begin
          p_start <= 1'b0;
          bcnt    <= '0;
          st      <= pick(1'b0, p_tx, p_rx, p_stop);
        end
        ST_TX: begin
          if (!last_bit) begin
            tx_sh <= tx_sh << 1;
            bcnt  <= bcnt + 1'b1;
          end else begin
            p_tx <= 1'b0;
            bcnt <= '0;
            if (io_rd_i) p_rx <= 1'b0;  // NAK drops the receive step
            st <= pick(1'b0, 1'b0, p_rx && !io_rd_i, p_stop);
          end
        end
        ST_RX: begin
          if (!last_bit) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], io_rd_i};
            bcnt  <= bcnt + 1'b1;
          end else begin
            rx_byte_o <= rx_sh;
            p_rx      <= 1'b0;
            bcnt      <= '0;
            st        <= pick(1'b0, 1'b0, 1'b0, p_stop);
          end
        end
        ST_STOP: begin
          {p_start, p_tx, p_rx, p_last, p_stop} <= '0;
          st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eng_status.sv
module i2c_eng_status
  import i2c_eng_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  input  logic [STS_W-1:0] en_i,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | set_i;  // set wins
  end

  assign irq_o = |(sts_o & en_i);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                cmd_we_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic                buf_we_i,
  input  logic [BYTE_W-1:0]   buf_i,
  output logic [2*BYTE_W-1:0] buf_o,
  input  logic [STS_W-1:0]    irq_en_i,
  input  logic [STS_W-1:0]    sts_clr_i,
  output logic [STS_W-1:0]    sts_o,
  output logic                irq_o,
  output logic                busy_o,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_oe_o,
  output logic                sda_oe_o
);
  logic [BYTE_W-1:0] tx_q, rx_byte;
  logic [STS_W-1:0]  sts_set;
  logic              io_req, io_wr, io_arb_en, io_busy, io_done, io_rd, io_arb;
  op_e               io_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_q <= '0;
    else if (buf_we_i) tx_q <= buf_i;
  end

  assign buf_o = {rx_byte, tx_q};

  i2c_eng_seq u_seq (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_i,
    .tx_byte_i  (tx_q),
    .io_busy_i  (io_busy),
    .io_done_i  (io_done),
    .io_rd_i    (io_rd),
    .io_arb_i   (io_arb),
    .io_req_o   (io_req),
    .io_op_o    (io_op),
    .io_wr_o    (io_wr),
    .io_arb_en_o(io_arb_en),
    .rx_byte_o  (rx_byte),
    .sts_set_o  (sts_set),
    .busy_o
  );

  i2c_eng_bitio u_io (
    .clk_i, .rst_ni, .tick_i,
    .req_i   (io_req),
    .op_i    (io_op),
    .wr_i    (io_wr),
    .arb_en_i(io_arb_en),
    .scl_i, .sda_i,
    .busy_o  (io_busy),
    .done_o  (io_done),
    .rd_o    (io_rd),
    .arb_o   (io_arb),
    .scl_oe_o, .sda_oe_o
  );

  i2c_eng_status u_sts (
    .clk_i, .rst_ni,
    .set_i(sts_set),
    .clr_i(sts_clr_i),
    .en_i (irq_en_i),
    .sts_o,
    .irq_o
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
  import i2c_eng_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [STS_W-1:0] sts_o,
  input logic [STS_W-1:0] sts_clr_i,
  input logic             scl_oe_o,
  input logic             sda_oe_o
);
  // R8
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(sts_o) & ~$past(sts_clr_i)) & ~sts_o) == '0));

  // R2
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sts_o & ~$past(sts_o)));

  // R10
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[S_ARB]) |-> (!sda_oe_o && !scl_oe_o));

  // R7
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[S_STP]) |-> (!sda_oe_o && !scl_oe_o));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sts_o(sts_o), .sts_clr_i(sts_clr_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4ns clk = ~clk;

  logic [1:0]  tcnt = '0;
  logic        tick;
  logic        cmd_we = 1'b0, buf_we = 1'b0;
  logic [5:0]  cmd_d = '0, irq_en = '0, sts_clr = '0;
  logic [7:0]  buf_d = '0;
  logic [15:0] buf_q;
  logic [5:0]  sts;
  logic        irq, busy, scl_oe, sda_oe;
  logic        scl_w, sda_w;
  logic        slv_low = 1'b0, jam = 1'b0, slv_ack = 1'b1, slv_read = 1'b0;
  logic [7:0]  rd0 = '0, rd1 = '0, got = '0, sh = '0;
  logic        mack = 1'b1, scl_q = 1'b1, sda_q = 1'b1;
  int          bcnt = -2, bidx = 0;
  int          n_run = 0, n_fail = 0;

  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick  = (tcnt == 2'd3);
  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_low | jam);

  i2c_byte_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cmd_we_i(cmd_we), .cmd_i(cmd_d), .buf_we_i(buf_we), .buf_i(buf_d), .buf_o(buf_q),
    .irq_en_i(irq_en), .sts_clr_i(sts_clr), .sts_o(sts), .irq_o(irq), .busy_o(busy),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // target model: changes SDA only after SCL falls
  always @(negedge clk) begin
    if (scl_q && scl_w && sda_q && !sda_w) begin
      bcnt = -1; bidx = 0; slv_low = 1'b0;
    end else if (scl_q && scl_w && !sda_q && sda_w) begin
      bcnt = -2; slv_low = 1'b0;
    end else if (scl_q && !scl_w && bcnt != -2) begin
      bcnt = bcnt + 1;
      if (bcnt == 9) begin bcnt = 0; bidx = bidx + 1; end
      if (bcnt == 8)
        slv_low = (bidx == 0 || !slv_read) ? slv_ack : 1'b0;
      else if (slv_read && bidx == 1) slv_low = ~rd0[7-bcnt];
      else if (slv_read && bidx == 2) slv_low = ~rd1[7-bcnt];
      else slv_low = 1'b0;
    end else if (!scl_q && scl_w && bcnt >= 0) begin
      if (bcnt < 8) sh = {sh[6:0], sda_w};
      else if (bidx == 0 || !slv_read) got = sh;
      else mack = sda_w;
    end
    scl_q = scl_w; sda_q = sda_w;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); buf_we = 1'b1; buf_d = b;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic issue(input logic [5:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_d = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) check(1'b0, "watchdog", 1, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); sts_clr = 6'h3F;
    @(negedge clk); sts_clr = 6'h00;
  endtask

  task automatic t_reset();
    check(sts == 0 && !irq && !busy, "R1 status", sts, 0);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    check(buf_q == 16'h0, "R1 buffer", buf_q, 0);
  endtask

  task automatic t_write();
    slv_ack = 1'b1; slv_read = 1'b0;
    load(8'hA0); issue(6'h03); wait_idle();
    check(sts == 6'h01, "R2 addr ack status", sts, 6'h01);
    check(got == 8'hA0, "R2 addr byte on bus", got, 8'hA0);
    check(scl_oe, "R2 bus held", scl_oe, 1);
    clear_all();
    load(8'h5C); issue(6'h02); wait_idle();
    check(sts == 6'h01, "R3 data ack status", sts, 6'h01);
    check(got == 8'h5C, "R3 data byte on bus", got, 8'h5C);
    clear_all();
    issue(6'h20); wait_idle();
    check(sts == 6'h10, "R7 stop status", sts, 6'h10);
    check(!scl_oe && !sda_oe && scl_w && sda_w, "R7 bus idle", {scl_w, sda_w}, 3);
    clear_all();
  endtask

  task automatic t_nak();
    slv_ack = 1'b0; slv_read = 1'b0;
    load(8'h42); issue(6'h0B); wait_idle();
    check(sts == 6'h02, "R6 nak drops rx", sts, 6'h02);
    clear_all();
    issue(6'h20); wait_idle();
    check(sts == 6'h10, "R7 stop after nak", sts, 6'h10);
    clear_all();
    slv_ack = 1'b1;
  endtask

  task automatic t_read();
    slv_ack = 1'b1; slv_read = 1'b1; rd0 = 8'h3C; rd1 = 8'hE7;
    load(8'hA1); issue(6'h0B); wait_idle();
    check(sts == 6'h05, "R6 combined status", sts, 6'h05);
    check(buf_q[15:8] == 8'h3C, "R4 rx byte", buf_q[15:8], 8'h3C);
    check(mack == 1'b0, "R4 master ack", mack, 0);
    irq_en = 6'h02; @(negedge clk);
    check(!irq, "R9 masked", irq, 0);
    irq_en = 6'h04; @(negedge clk);
    check(irq, "R9 enabled", irq, 1);
    @(negedge clk); sts_clr = 6'h01; @(negedge clk); sts_clr = 6'h00;
    check(sts == 6'h04, "R8 w1c single bit", sts, 6'h04);
    clear_all();
    check(!irq, "R9 cleared", irq, 0);
    irq_en = 6'h00;
    issue(6'h18); wait_idle();
    check(buf_q[15:8] == 8'hE7, "R5 rx byte", buf_q[15:8], 8'hE7);
    check(mack == 1'b1, "R5 master nack", mack, 1);
    clear_all();
    issue(6'h20); wait_idle();
    clear_all();
    slv_read = 1'b0;
  endtask

  task automatic t_busy();
    load(8'hA0); issue(6'h03);
    check(busy, "R12 busy", busy, 1);
    issue(6'h20); wait_idle();
    check(sts == 6'h01, "R12 stop ignored", sts, 6'h01);
    check(scl_oe, "R12 bus still held", scl_oe, 1);
    clear_all();
    issue(6'h20); wait_idle();
    clear_all();
  endtask

  task automatic t_abn();
    issue(6'h02); repeat (2) @(negedge clk);
    check(sts == 6'h20 && !busy, "R11 tx without start", sts, 6'h20);
    check(!scl_oe && !sda_oe, "R11 lines untouched", {scl_oe, sda_oe}, 0);
    clear_all();
    issue(6'h05); repeat (2) @(negedge clk);
    check(sts == 6'h20 && !busy, "R11 reserved bit", sts, 6'h20);
    clear_all();
  endtask

  task automatic t_arb();
    jam = 1'b1;
    load(8'hA5); issue(6'h0B); wait_idle();
    check(sts == 6'h08, "R10 arb status", sts, 6'h08);
    check(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    jam = 1'b0; repeat (4) @(negedge clk);
    clear_all();
    check(!busy && sts == 0, "R10 idle after loss", sts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_nak();
    t_read();
    t_busy();
    t_abn();
    t_arb();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule